// File: doc/BRIEF.md
# Per-Node Request Acceptance Filter

This block decides, for each incoming asynchronous request header, whether the request may be acknowledged and queued. The decision depends on the source bus and node number, the target context, and a 32-bit enable mask that covers the upper half of the node number space. Bits 30..0 of the mask enable source nodes 62..32 in order, so node n uses bit n-32. Bit 31 gates requests that come from any other bus.

Software never writes the mask directly. One write port sets the mask bits where its data holds ones. A second port clears the mask bits where its data holds ones. Zero bits on either port leave the mask unchanged. The mask is always visible on a read output.

The header side takes a one-cycle valid strobe together with the 16-bit source ID and a 2-bit context code. One clock later, the block presents a registered accept/reject result.

Top module: `req_accept_filter`

## Requirements
- R1: After a synchronous active-low reset, the mask reads 0x00000000, and `dec_valid` and `dec_accept` are 0.
- R2: A write on the set port turns on every mask bit whose data bit is 1 and leaves all other bits unchanged.
- R3: A write on the clear port turns off every mask bit whose data bit is 1 and leaves all other bits unchanged.
- R4: When set and clear writes occur in the same cycle, a bit named by both ends up 0. Bits named only by the set data end up 1.
- R5: `mask_rd` shows the mask and reflects a write from the clock edge at which that write is taken.
- R6: Context codes 2 and 3 are not filtered and always give accept = 1. Code 0 is the physical-request context and code 1 is the request-receive context.
- R7: For context 0 or 1 from a local bus and a source node n in 32..62, accept equals mask bit n-32 as it stood in the strobe cycle.
- R8: For context 0 or 1 from a local bus, the broadcast node 63 is always rejected.
- R9: For context 0 or 1 from a local bus, nodes 0..31 give accept = 1, because those nodes belong to a different filter.
- R10: The source ID carries the bus in bits 15:6 and the node in bits 5:0. A bus field equal to `local_bus_id` or to 0x3FF is local. For context 0 or 1 from any other bus, accept equals mask bit 31.
- R11: `dec_valid` is 1 exactly one cycle after `hdr_valid`. When `dec_valid` is 0, `dec_accept` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_we | input | 1 | Set-port write strobe |
| set_data | input | 32 | Bits to turn on |
| clr_we | input | 1 | Clear-port write strobe |
| clr_data | input | 32 | Bits to turn off |
| mask_rd | output | 32 | Current enable mask |
| local_bus_id | input | 10 | Bus number of this controller |
| hdr_valid | input | 1 | Header strobe, one cycle per request |
| hdr_src_id | input | 16 | Source ID: bus in 15:6, node in 5:0 |
| hdr_ctx | input | 2 | Target context code |
| dec_valid | output | 1 | Decision present |
| dec_accept | output | 1 | 1 = acknowledge and queue |

## Verification
The bench fires set and clear writes in the same cycle with overlapping data. A design that let the set win, or that used plain assignment instead of one-bit updates, would leave bits on or wipe out neighbouring bits.

It also writes the mask in the same cycle as a header strobe. A design that looked up the mask after the update would give the wrong answer for that request.

The directed cases cover node 63, node 32 (bit 0), node 62 (bit 30), node 31, and the bus value 0x3FF. These expose an off-by-one error in the bit index, a broadcast node that is wrongly enabled, and a remote bus that is not gated by bit 31.

Random headers spread over all four context codes then check that contexts 2 and 3 always pass and that the decision arrives with exactly one cycle of latency.

// File: rtl/rqf_pkg.sv
// Shared sizes and context codes for the request acceptance filter.
// Assumes a 16-bit source ID: the bus number sits above the node number.
package rqf_pkg;
    localparam int NODE_W = 6;
    localparam int BUS_W  = 10;
    localparam int SRC_W  = BUS_W + NODE_W;
    localparam int MASK_W = 1 << (NODE_W - 1);
    localparam int IDX_W  = NODE_W - 1;

    typedef enum logic [1:0] {
        CTX_PHYS_REQ = 2'd0,
        CTX_REQ_RX   = 2'd1,
        CTX_RESP     = 2'd2,
        CTX_OTHER    = 2'd3
    } ctx_e;

    // Only the two request contexts are subject to filtering.
    function automatic logic ctx_filtered(input logic [1:0] ctx);
        return (ctx == CTX_PHYS_REQ) || (ctx == CTX_REQ_RX);
    endfunction
endpackage

// File: rtl/rqf_mask_reg.sv
// Enable mask with write-one-to-set and write-one-to-clear ports.
// Assumes both ports may fire in one cycle; clear has priority per bit.
module rqf_mask_reg #(
    parameter int MASK_W = rqf_pkg::MASK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic [MASK_W-1:0] set_data,
    input  logic              clr_we,
    input  logic [MASK_W-1:0] clr_data,
    output logic [MASK_W-1:0] mask_q
);
    logic [MASK_W-1:0] set_hit;
    logic [MASK_W-1:0] clr_hit;

    // Qualify write data with their strobes.
    always_comb begin
        set_hit = set_we ? set_data : '0;
        clr_hit = clr_we ? clr_data : '0;
    end

    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
        // Per-bit update: clear beats set, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[i] <= 1'b0;
            else if (clr_hit[i])
                mask_q[i] <= 1'b0;
            else if (set_hit[i])
                mask_q[i] <= 1'b1;
        end
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((mask_q & $past(clr_data)) == '0)); // R4
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we) |=> ((mask_q & $past(set_data)) == $past(set_data))); // R2
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(mask_q)); // R5
endmodule

// File: rtl/rqf_src_classify.sv
// Splits a source ID into bus and node and classifies it for the filter.
// Assumes the upper node half starts at 2**(NODE_W-1); all-ones is broadcast.
module rqf_src_classify #(
    parameter int NODE_W = rqf_pkg::NODE_W,
    parameter int BUS_W  = rqf_pkg::BUS_W,
    localparam int SRC_W = BUS_W + NODE_W,
    localparam int IDX_W = NODE_W - 1
) (
    input  logic [SRC_W-1:0] src_id,
    input  logic [BUS_W-1:0] local_bus_id,
    output logic             is_remote,
    output logic             is_bcast,
    output logic             is_upper,
    output logic [IDX_W-1:0] bit_idx
);
    logic [BUS_W-1:0]  bus;
    logic [NODE_W-1:0] node;

    // Field extraction and classification of the source.
    always_comb begin
        bus       = src_id[SRC_W-1:NODE_W];
        node      = src_id[NODE_W-1:0];
        is_remote = (bus != local_bus_id) && (bus != {BUS_W{1'b1}});
        is_bcast  = (node == {NODE_W{1'b1}});
        is_upper  = node[NODE_W-1] && !is_bcast;
        bit_idx   = node[IDX_W-1:0];
    end
endmodule

// File: rtl/rqf_decide.sv
// Registers the accept decision one clock after the header strobe.
// Assumes the classification inputs are valid in the strobe cycle.
module rqf_decide #(
    parameter int MASK_W = rqf_pkg::MASK_W,
    localparam int IDX_W = $clog2(MASK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_valid,
    input  logic [1:0]        hdr_ctx,
    input  logic [MASK_W-1:0] mask,
    input  logic              is_remote,
    input  logic              is_bcast,
    input  logic              is_upper,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic              dec_valid,
    output logic              dec_accept
);
    logic accept_d;

    // Decision priority: context pass, remote gate, broadcast, upper lookup.
    always_comb begin
        if (!rqf_pkg::ctx_filtered(hdr_ctx))
            accept_d = 1'b1;
        else if (is_remote)
            accept_d = mask[MASK_W-1];
        else if (is_bcast)
            accept_d = 1'b0;
        else if (is_upper)
            accept_d = mask[bit_idx];
        else
            accept_d = 1'b1;
    end

    // Output register, zeroed when no header was presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= hdr_valid;
            dec_accept <= hdr_valid && accept_d;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> dec_valid); // R11
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> (!dec_valid && !dec_accept)); // R11
    AST_PASS_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ctx[1]) |=> dec_accept); // R6
    AST_BCAST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_ctx[1] && !is_remote && is_bcast) |=> !dec_accept); // R8
endmodule

// File: rtl/req_accept_filter.sv
// Top of the request acceptance filter: mask register, source classifier
// and registered decision stage. Assumes one header per strobe cycle.
module req_accept_filter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_we,
    input  logic [31:0] set_data,
    input  logic        clr_we,
    input  logic [31:0] clr_data,
    output logic [31:0] mask_rd,
    input  logic [9:0]  local_bus_id,
    input  logic        hdr_valid,
    input  logic [15:0] hdr_src_id,
    input  logic [1:0]  hdr_ctx,
    output logic        dec_valid,
    output logic        dec_accept
);
    import rqf_pkg::*;

    logic [MASK_W-1:0] mask_q;
    logic              is_remote;
    logic              is_bcast;
    logic              is_upper;
    logic [IDX_W-1:0]  bit_idx;

    rqf_mask_reg #(.MASK_W(MASK_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (set_we),
        .set_data (set_data),
        .clr_we   (clr_we),
        .clr_data (clr_data),
        .mask_q   (mask_q)
    );

    rqf_src_classify #(.NODE_W(NODE_W), .BUS_W(BUS_W)) u_cls (
        .src_id       (hdr_src_id),
        .local_bus_id (local_bus_id),
        .is_remote    (is_remote),
        .is_bcast     (is_bcast),
        .is_upper     (is_upper),
        .bit_idx      (bit_idx)
    );

    rqf_decide #(.MASK_W(MASK_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_valid  (hdr_valid),
        .hdr_ctx    (hdr_ctx),
        .mask       (mask_q),
        .is_remote  (is_remote),
        .is_bcast   (is_bcast),
        .is_upper   (is_upper),
        .bit_idx    (bit_idx),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept)
    );

    // Read path exposes the live mask.
    always_comb mask_rd = mask_q;

    AST_REMOTE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_ctx[1] && is_remote) |=> (dec_accept == $past(mask_rd[31]))); // R10
endmodule

// File: tb/tb_req_accept_filter.sv
module tb_req_accept_filter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        set_we, clr_we, hdr_valid;
    logic [31:0] set_data, clr_data, mask_rd;
    logic [9:0]  local_bus_id;
    logic [15:0] hdr_src_id;
    logic [1:0]  hdr_ctx;
    logic        dec_valid, dec_accept;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_mask;
    localparam logic [9:0] LBUS = 10'h0A5;

    always #2 clk = ~clk;

    req_accept_filter dut (
        .clk(clk), .rst_n(rst_n), .set_we(set_we), .set_data(set_data),
        .clr_we(clr_we), .clr_data(clr_data), .mask_rd(mask_rd),
        .local_bus_id(local_bus_id), .hdr_valid(hdr_valid),
        .hdr_src_id(hdr_src_id), .hdr_ctx(hdr_ctx),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    function automatic logic exp_accept(input logic [31:0] m, input logic [1:0] ctx,
                                        input logic [9:0] bus, input logic [5:0] node);
        if (ctx[1]) return 1'b1;
        if (bus != LBUS && bus != 10'h3FF) return m[31];
        if (node == 6'd63) return 1'b0;
        if (node < 6'd32) return 1'b1;
        return m[node - 6'd32];
    endfunction

    function automatic string req_tag(input logic [1:0] ctx, input logic [9:0] bus,
                                      input logic [5:0] node);
        if (ctx[1]) return "R6";
        if (bus != LBUS && bus != 10'h3FF) return "R10";
        if (node == 6'd63) return "R8";
        if (node < 6'd32) return "R9";
        return "R7";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: apply inputs, advance, compare with the model.
    task automatic cyc(input logic sw, input logic [31:0] sd, input logic cw,
                       input logic [31:0] cd, input logic hv, input logic [1:0] ctx,
                       input logic [9:0] bus, input logic [5:0] node, input string wtag);
        logic ea;
        string t;
        set_we = sw; set_data = sd; clr_we = cw; clr_data = cd;
        hdr_valid = hv; hdr_ctx = ctx; hdr_src_id = {bus, node};
        ea = hv && exp_accept(model_mask, ctx, bus, node);
        t = req_tag(ctx, bus, node);
        if (sw) model_mask = model_mask | sd;
        if (cw) model_mask = model_mask & ~cd;
        @(posedge clk); #1;
        chk("R11", {31'd0, dec_valid}, {31'd0, hv});
        chk(hv ? t : "R11", {31'd0, dec_accept}, {31'd0, ea});
        chk(wtag, mask_rd, model_mask);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1394));
        model_mask = '0;
        local_bus_id = LBUS;
        rst_n = 1'b0; set_we = 0; clr_we = 0; set_data = '1; clr_data = 0;
        hdr_valid = 1; hdr_ctx = 0; hdr_src_id = 0;
        repeat (3) @(posedge clk);
        #1;
        set_we = 0; hdr_valid = 0;
        @(posedge clk); #1;
        chk("R1", mask_rd, 32'h0);
        chk("R1", {30'd0, dec_valid, dec_accept}, 32'h0);
        rst_n = 1'b1;

        // Directed: set, clear, simultaneous overlap.
        cyc(1, 32'hF0F0_00FF, 0, 0, 0, 0, LBUS, 0, "R2");
        cyc(1, 32'h0000_0F00, 0, 0, 0, 0, LBUS, 0, "R2");
        cyc(0, 0, 1, 32'h00F0_000F, 0, 0, LBUS, 0, "R3");
        cyc(1, 32'h0003_0003, 1, 32'h0001_00F0, 0, 0, LBUS, 0, "R4");
        chk("R4", mask_rd & 32'h0001_00F0, 32'h0);
        cyc(1, 32'h4000_0001, 0, 0, 0, 0, LBUS, 0, "R5");
        // Directed decisions on edges of the node range.
        cyc(0, 0, 0, 0, 1, 2'd0, LBUS, 6'd32, "R5");
        cyc(0, 0, 0, 0, 1, 2'd1, LBUS, 6'd62, "R5");
        cyc(0, 0, 0, 0, 1, 2'd0, LBUS, 6'd63, "R5");
        cyc(0, 0, 0, 0, 1, 2'd1, LBUS, 6'd31, "R5");
        cyc(0, 0, 0, 0, 1, 2'd0, 10'h3FF, 6'd33, "R5");
        cyc(0, 0, 0, 0, 1, 2'd0, 10'h001, 6'd32, "R5");
        cyc(1, 32'h8000_0000, 0, 0, 1, 2'd1, 10'h001, 6'd40, "R5");
        cyc(0, 0, 0, 0, 1, 2'd0, 10'h001, 6'd40, "R5");
        cyc(0, 0, 1, 32'h0000_0001, 1, 2'd0, LBUS, 6'd32, "R5");
        cyc(0, 0, 0, 0, 1, 2'd0, LBUS, 6'd32, "R5");
        cyc(0, 0, 0, 0, 1, 2'd3, 10'h002, 6'd63, "R5");

        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            logic [9:0] bus;
            int r = $urandom_range(0, 3);
            bus = (r == 0) ? 10'h3FF : (r == 1) ? $urandom() : LBUS;
            cyc($urandom_range(0, 3) == 0, $urandom(), $urandom_range(0, 3) == 0, $urandom(),
                $urandom_range(0, 2) != 0, 2'($urandom()), bus, 6'($urandom()), "R5");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule